// File: doc/BRIEF.md
# Multi-Stage Pattern Trigger

This block watches a bus of digital channels and raises a trigger once a programmed sequence of channel patterns has been seen in order. The sequence has up to four stages. Each stage gives every channel one condition: ignore it, require it low, require it high, require a rising edge, or require a falling edge. A stage is satisfied only in a cycle where all its non-ignored conditions hold together. Once a stage is satisfied, that stage's own delay counter must run out before the next stage starts to be evaluated.

Software loads the condition words, the per-stage delays and the index of the final stage, then pulses `arm`. The block walks through the stages and shows the stage it is waiting on. When the final stage is satisfied and its delay has run out, it sends a single-cycle `trig` pulse and goes idle. A new `arm` starts the next run. Configuration inputs are sampled live and must be held steady while the block is armed.

Top module: `seq_pattern_trig`

## Requirements
- R1: After synchronous reset, `trig` is 0, `armed` is 0 and `stage_idx` is 0.
- R2: `arm` high at a clock edge puts the block in stage 0 with `armed` high and all delay counters cleared. This takes priority over any match and also restarts a run that is in progress.
- R3: The condition code of channel c in stage s sits at `stage_cfg[(s*N_CH+c)*3 +: 3]`. Code 0 ignores the channel, 1 requires it low and 2 requires it high. The spare codes 5, 6 and 7 also ignore the channel.
- R4: Code 3 requires a rising edge and code 4 a falling edge. An edge means the channel value differs from its value one clock earlier in the named direction.
- R5: A stage matches only in a cycle where every non-ignored channel condition holds at the same time.
- R6: The delay of stage s is `dly_cfg[s*DLY_W +: DLY_W]`. With a delay of 0, the stage advances at the clock edge that sees the match, so `stage_idx` shows the next stage in the following cycle.
- R7: With a delay D greater than 0, the stage advances D clock edges after the match edge. Channel values during the wait are ignored.
- R8: `last_stage` = k makes stage k the final stage, giving k+1 active stages. Stages above k are never entered.
- R9: Completing the final stage produces a `trig` pulse exactly one cycle long. In that same cycle `armed` drops and `stage_idx` returns to 0. Channel activity has no effect until the next `arm`.
- R10: Only the current stage is evaluated. A pattern that satisfies a later stage, but not the current one, does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start or restart the sequence at stage 0 |
| ch_in | input | N_CH | Sampled digital channels |
| stage_cfg | input | N_STAGE*N_CH*3 | Per-stage, per-channel condition codes |
| dly_cfg | input | N_STAGE*DLY_W | Per-stage delay in clock cycles |
| last_stage | input | IDX_W | Index of the final stage |
| trig | output | 1 | One-cycle trigger pulse |
| stage_idx | output | IDX_W | Stage currently awaited |
| armed | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach is a stage that is in the middle of its delay wait, because it exists only for a few cycles after a match that itself depends on the stages before it. The stimulus walks a table of channel patterns through a full four-stage sequence that mixes level and edge stages. It then deliberately re-arms while stage 1 is waiting out its delay, and confirms that the run restarts cleanly. Separate runs with a single stage and a long delay place the trigger edge precisely, and a run that ends at stage 1 checks that the final-stage setting is honoured.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        COND_ANY  = 3'd0,
        COND_LO   = 3'd1,
        COND_HI   = 3'd2,
        COND_RISE = 3'd3,
        COND_FALL = 3'd4
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

    // One channel condition against current and previous sample
    function automatic logic cond_holds(input logic [COND_W-1:0] code,
                                        input logic cur,
                                        input logic prv);
        logic ok;
        case (code)
            COND_LO:   ok = !cur;
            COND_HI:   ok = cur;
            COND_RISE: ok = cur && !prv;
            COND_FALL: ok = !cur && prv;
            default:   ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/trig_stage_match.sv
module trig_stage_match
    import seq_trig_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic [N_CH*COND_W-1:0] cfg,
    input  logic [N_CH-1:0]        cur,
    input  logic [N_CH-1:0]        prv,
    output logic                   hit
);

    logic [N_CH-1:0] ok;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign ok[c] = cond_holds(cfg[c*COND_W +: COND_W], cur[c], prv[c]);
    end

    assign hit = &ok;

endmodule

// File: rtl/trig_dly_cnt.sv
module trig_dly_cnt #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - DLY_W'(1);
        end
    end

    assign expire = (cnt == DLY_W'(1));

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
    import seq_trig_pkg::*;
#(
    parameter int N_STAGE = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic [N_STAGE-1:0] hit_vec,
    input  logic [N_STAGE-1:0] expire_vec,
    input  logic [N_STAGE-1:0] dly_zero_vec,
    input  logic [IDX_W-1:0]   last_idx,
    output seq_state_e         state,
    output logic [IDX_W-1:0]   stage,
    output logic               fire,
    output logic [N_STAGE-1:0] load_vec,
    output logic [N_STAGE-1:0] tick_vec
);

    logic               cur_hit;
    logic               cur_zero;
    logic               cur_exp;
    logic               at_last;
    logic               advance;
    logic [N_STAGE-1:0] stage_oh;

    always_comb begin
        cur_hit  = hit_vec[stage];
        cur_zero = dly_zero_vec[stage];
        cur_exp  = expire_vec[stage];
        at_last  = (stage >= last_idx);
        stage_oh = N_STAGE'(1) << stage;
        advance  = ((state == ST_HUNT) && cur_hit && cur_zero) ||
                   ((state == ST_HOLD) && cur_exp);
        load_vec = ((state == ST_HUNT) && cur_hit && !cur_zero) ? stage_oh : '0;
        tick_vec = (state == ST_HOLD) ? stage_oh : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            stage <= '0;
            fire  <= 1'b0;
        end else if (arm) begin
            state <= ST_HUNT;
            stage <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (advance) begin
                if (at_last) begin
                    fire  <= 1'b1;
                    state <= ST_IDLE;
                    stage <= '0;
                end else begin
                    state <= ST_HUNT;
                    stage <= stage + IDX_W'(1);
                end
            end else if ((state == ST_HUNT) && cur_hit) begin
                state <= ST_HOLD;
            end
        end
    end

endmodule

// File: rtl/seq_pattern_trig.sv
module seq_pattern_trig
    import seq_trig_pkg::*;
#(
    parameter  int N_CH    = 8,
    parameter  int N_STAGE = 4,
    parameter  int DLY_W   = 16,
    localparam int IDX_W   = $clog2(N_STAGE),
    localparam int SCFG_W  = N_CH * COND_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       arm,
    input  logic [N_CH-1:0]            ch_in,
    input  logic [N_STAGE*SCFG_W-1:0]  stage_cfg,
    input  logic [N_STAGE*DLY_W-1:0]   dly_cfg,
    input  logic [IDX_W-1:0]           last_stage,
    output logic                       trig,
    output logic [IDX_W-1:0]           stage_idx,
    output logic                       armed
);

    logic [N_CH-1:0]    ch_prev;
    logic [N_STAGE-1:0] hit_vec;
    logic [N_STAGE-1:0] expire_vec;
    logic [N_STAGE-1:0] dly_zero_vec;
    logic [N_STAGE-1:0] load_vec;
    logic [N_STAGE-1:0] tick_vec;
    seq_state_e         state;

    // Previous sample for edge conditions
    always_ff @(posedge clk) begin
        ch_prev <= ch_in;
    end

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        trig_stage_match #(.N_CH(N_CH)) u_match (
            .cfg (stage_cfg[s*SCFG_W +: SCFG_W]),
            .cur (ch_in),
            .prv (ch_prev),
            .hit (hit_vec[s])
        );

        trig_dly_cnt #(.DLY_W(DLY_W)) u_dly (
            .clk      (clk),
            .rst      (rst),
            .clr      (arm),
            .load     (load_vec[s]),
            .load_val (dly_cfg[s*DLY_W +: DLY_W]),
            .tick     (tick_vec[s]),
            .expire   (expire_vec[s])
        );

        assign dly_zero_vec[s] = (dly_cfg[s*DLY_W +: DLY_W] == '0);
    end

    trig_seq_ctrl #(.N_STAGE(N_STAGE), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .hit_vec      (hit_vec),
        .expire_vec   (expire_vec),
        .dly_zero_vec (dly_zero_vec),
        .last_idx     (last_stage),
        .state        (state),
        .stage        (stage_idx),
        .fire         (trig),
        .load_vec     (load_vec),
        .tick_vec     (tick_vec)
    );

    assign armed = (state != ST_IDLE);

endmodule

// File: rtl/seq_pattern_trig_chk.sv
module seq_pattern_trig_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             trig,
    input logic             armed,
    input logic [IDX_W-1:0] stage_idx
);

    // R2: arming lands in stage 0, running, no trigger
    p_arm_restart_r2: assert property (@(posedge clk) disable iff (rst)
        arm |=> (armed && (stage_idx == '0) && !trig));

    // R9: trigger lasts a single cycle
    p_trig_single_r9: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    // R9: trigger coincides with end of the run
    p_trig_idle_r9: assert property (@(posedge clk) disable iff (rst)
        trig |-> (!armed && (stage_idx == '0)));

    // R1: idle always reports stage 0
    p_idle_stage0_r1: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (stage_idx == '0));

    // R10: while running, stage only holds or steps by one
    p_stage_step_r10: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !$past(arm)) |->
            ((stage_idx == $past(stage_idx)) ||
             (stage_idx == ($past(stage_idx) + IDX_W'(1)))));

    // R9: no new run begins without arm
    p_no_self_arm_r9: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm) |=> !armed);

endmodule

bind seq_pattern_trig seq_pattern_trig_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .trig      (trig),
    .armed     (armed),
    .stage_idx (stage_idx)
);

// File: tb/seq_pattern_trig_test.sv
`timescale 1ns/100ps
module seq_pattern_trig_test;

    localparam int NC = 8;
    localparam int NS = 4;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              arm = 1'b0;
    logic [NC-1:0]     ch_in = '0;
    logic [NS*NC*3-1:0] stage_cfg = '0;
    logic [NS*DW-1:0]  dly_cfg = '0;
    logic [1:0]        last_stage = 2'd3;
    logic              trig;
    logic [1:0]        stage_idx;
    logic              armed;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    seq_pattern_trig #(.N_CH(NC), .N_STAGE(NS), .DLY_W(DW)) uut (
        .clk(clk), .rst(rst), .arm(arm), .ch_in(ch_in),
        .stage_cfg(stage_cfg), .dly_cfg(dly_cfg), .last_stage(last_stage),
        .trig(trig), .stage_idx(stage_idx), .armed(armed)
    );

    typedef struct packed {
        logic       a;
        logic [7:0] ch;
        logic       e_trig;
        logic       e_armed;
        logic [1:0] e_stage;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b1, 8'h00, 1'b0, 1'b1, 2'd0, 4'd2},  // R2 arm
        '{1'b0, 8'h01, 1'b0, 1'b1, 2'd1, 4'd6},  // R6 stage0 levels, zero delay
        '{1'b0, 8'h04, 1'b0, 1'b1, 2'd1, 4'd4},  // R4 rise ch2, delay 2 starts
        '{1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 4'd7},  // R7 waiting
        '{1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 4'd7},  // R7 expired
        '{1'b0, 8'h08, 1'b0, 1'b1, 2'd2, 4'd4},  // R4 no fall yet
        '{1'b0, 8'h00, 1'b0, 1'b1, 2'd3, 4'd4},  // R4 fall ch3, code 5 ignored (R3)
        '{1'b0, 8'h10, 1'b0, 1'b1, 2'd3, 4'd5},  // R5 only one of two highs
        '{1'b0, 8'h30, 1'b0, 1'b1, 2'd3, 4'd5},  // R5 both high, delay 1
        '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 4'd9},  // R9 trigger
        '{1'b0, 8'h30, 1'b0, 1'b0, 2'd0, 4'd9},  // R9 one cycle, idle
        '{1'b1, 8'h00, 1'b0, 1'b1, 2'd0, 4'd2},  // R2 re-arm
        '{1'b0, 8'h30, 1'b0, 1'b1, 2'd0, 4'd10}, // R10 later pattern ignored
        '{1'b0, 8'h03, 1'b0, 1'b1, 2'd0, 4'd3},  // R3 ch1 must be low
        '{1'b0, 8'h01, 1'b0, 1'b1, 2'd1, 4'd6},  // R6 advance
        '{1'b0, 8'h04, 1'b0, 1'b1, 2'd1, 4'd7},  // R7 into delay
        '{1'b1, 8'h00, 1'b0, 1'b1, 2'd0, 4'd2},  // R2 re-arm mid delay
        '{1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 4'd2},  // R2 stays at stage 0
        '{1'b0, 8'h01, 1'b0, 1'b1, 2'd1, 4'd2}   // R2 fresh run advances
    };

    task automatic set_cond(input int s, input int c, input logic [2:0] code);
        stage_cfg[(s*NC+c)*3 +: 3] = code;
    endtask

    task automatic check(input string rq, input logic e_trig, input logic e_armed,
                         input logic [1:0] e_stage);
        n_run++;
        if (trig !== e_trig || armed !== e_armed || stage_idx !== e_stage) begin
            n_fail++;
            $display("FAIL %s: trig/armed/stage got %b/%b/%0d expected %b/%b/%0d",
                     rq, trig, armed, stage_idx, e_trig, e_armed, e_stage);
        end
    endtask

    task automatic step(input logic a, input logic [7:0] ch);
        @(negedge clk);
        arm   = a;
        ch_in = ch;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        // Sequence configuration
        set_cond(0, 0, 3'd2); set_cond(0, 1, 3'd1);
        set_cond(1, 2, 3'd3);
        set_cond(2, 3, 3'd4); set_cond(2, 0, 3'd5);
        set_cond(3, 4, 3'd2); set_cond(3, 5, 3'd2);
        dly_cfg[0*DW +: DW] = 16'd0;
        dly_cfg[1*DW +: DW] = 16'd2;
        dly_cfg[2*DW +: DW] = 16'd0;
        dly_cfg[3*DW +: DW] = 16'd1;
        last_stage = 2'd3;

        repeat (4) @(posedge clk);
        #1;
        check("R1", 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 8'h00);
        check("R1", 1'b0, 1'b0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].a, TBL[i].ch);
            check($sformatf("R%0d", TBL[i].rq), TBL[i].e_trig,
                  TBL[i].e_armed, TBL[i].e_stage);
        end
        step(1'b0, 8'h00);

        // R8: end at stage 1
        step(1'b0, 8'h00);
        last_stage = 2'd1;
        step(1'b1, 8'h00);
        step(1'b0, 8'h01);
        check("R8", 1'b0, 1'b1, 2'd1);
        step(1'b0, 8'h04);
        step(1'b0, 8'h00);
        check("R8", 1'b0, 1'b1, 2'd1);
        step(1'b0, 8'h00);
        check("R8", 1'b1, 1'b0, 2'd0);

        // R6: single stage, all ignore, zero delay
        stage_cfg = '0;
        dly_cfg = '0;
        last_stage = 2'd0;
        step(1'b1, 8'h00);
        check("R6", 1'b0, 1'b1, 2'd0);
        step(1'b0, 8'hA5);
        check("R6", 1'b1, 1'b0, 2'd0);

        // R7: single stage, delay 5
        dly_cfg[0*DW +: DW] = 16'd5;
        step(1'b1, 8'h00);
        step(1'b0, 8'h00);
        for (int k = 1; k < 5; k++) begin
            step(1'b0, 8'hFF);
            check("R7", 1'b0, 1'b1, 2'd0);
        end
        step(1'b0, 8'h00);
        check("R7", 1'b1, 1'b0, 2'd0);
        step(1'b0, 8'h00);
        check("R9", 1'b0, 1'b0, 2'd0);

        // R1: reset in mid run
        step(1'b1, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        rst = 1'b0;

        finish_run();
    end

endmodule